// File: doc/BRIEF.md
# Granule protection table walker

This block finds the protection index of a physical address by walking a two-level table in memory. A request gives the physical address together with three configuration fields: the protected-space size code, the granule-size code and the level-0 region-size code. The walker reads one 64-bit level-0 descriptor. That descriptor either settles the whole region at once, as a block, or points to a level-1 table. In the table case the walker reads one 64-bit level-1 word and takes the index from it.

A level-1 word is read in one of two ways. It is either sixteen packed 4-bit indices, one per granule, or a single index that covers a contiguous run. Bad configuration codes, addresses outside the protected space and malformed descriptors each return a fault code in place of an index. Only one walk runs at a time. The memory port allows one outstanding 64-bit read.

Top module: `gpt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. After a request is accepted, `req_ready` stays low until the cycle after the response pulse. At most one memory read is outstanding.
- R2: A protected-size code above 6, a granule code of 3, or a region-size code above 9 returns a fault of kind 0 (configuration). No memory read is made.
- R3: If the address is at or above 2^T, the walker returns a fault of kind 1 (range) and makes no memory read.
- R4: The region shift is S = region-size code + 30. The level-0 read address is `cfg_l0_base` + (PA >> S) * 8. When S >= T the index is always zero, so only one level-0 entry is used.
- R5: A level-0 descriptor with bits [3:0] = 1 is a block. The walker returns bits [7:4] as the index, with no fault and `rsp_at_l1` = 0.
- R6: A level-0 type other than 1 or 3 returns a fault of kind 2 (descriptor) with `rsp_at_l1` = 0.
- R7: A level-0 type of 3 is a table. The level-1 base is descriptor bits [51:12] placed at bit 12, and all other descriptor bits are ignored. The level-1 read address is that base + PA[S-1:P+4] * 8.
- R8: A level-1 word whose low nibble is not 1 holds per-granule indices. The walker returns nibble (PA >> P) & 0xF, where nibble 0 is bits [3:0], and sets `rsp_at_l1` = 1.
- R9: A level-1 word whose low nibble is 1 is a contiguous run. A size code in bits [9:8] of 1, 2 or 3 returns bits [7:4] as the index. A size code of 0 returns a fault of kind 2 with `rsp_at_l1` = 1.
- R10: Granule code 0 gives P = 12, code 2 gives P = 14 and code 1 gives P = 16.
- R11: Protected-size codes 0 to 6 give T = 32, 36, 40, 42, 44, 48, 52.
- R12: `rsp_valid` is a one-cycle pulse. On a fault `rsp_gpi` is 0. `mem_req_valid` holds with a stable address until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_pa | input | PA_W | Physical address to check |
| cfg_pps | input | 3 | Protected-space size code |
| cfg_pgs | input | 2 | Granule size code |
| cfg_l0sz | input | 4 | Level-0 region size code |
| cfg_l0_base | input | PA_W | Level-0 table base |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory read accepted |
| mem_req_addr | output | PA_W | Byte address of 64-bit read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_gpi | output | 4 | Protection index |
| rsp_fault | output | 1 | Walk faulted |
| rsp_kind | output | 2 | Fault kind: 0 config, 1 range, 2 descriptor |
| rsp_at_l1 | output | 1 | Walk ended at level 1 |

## Verification
The bench builds the walker with its default 52-bit address width, so the whole protected-size range is reachable, up to T = 52 with a level-0 index of more than twenty bits. Region-size code 2 against T = 32 makes S equal T, which exercises the single-entry case. All three granule codes index the same level-1 table, so the out-of-order 16KB and 64KB codes pick different entries and nibbles. A table descriptor with junk outside bits [51:12] shows that only the base field is used.

// File: rtl/gpt_walker.sv
module gpt_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_pa,
  input  logic [2:0]      cfg_pps,
  input  logic [1:0]      cfg_pgs,
  input  logic [3:0]      cfg_l0sz,
  input  logic [PA_W-1:0] cfg_l0_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  output logic [3:0]      rsp_gpi,
  output logic            rsp_fault,
  output logic [1:0]      rsp_kind,
  output logic            rsp_at_l1
);
  localparam logic [1:0] K_CFG = 2'd0, K_RANGE = 2'd1, K_DESC = 2'd2;

  typedef enum logic [2:0] {IDLE, L0_REQ, L0_WAIT, L1_REQ, L1_WAIT, RESP} st_t;
  st_t st;

  function automatic logic [5:0] t_of(input logic [2:0] code);
    case (code)
      3'd0: t_of = 6'd32;
      3'd1: t_of = 6'd36;
      3'd2: t_of = 6'd40;
      3'd3: t_of = 6'd42;
      3'd4: t_of = 6'd44;
      3'd5: t_of = 6'd48;
      default: t_of = 6'd52;
    endcase
  endfunction

  function automatic logic [4:0] p_of(input logic [1:0] code);
    case (code)
      2'b10: p_of = 5'd14;
      2'b01: p_of = 5'd16;
      default: p_of = 5'd12;
    endcase
  endfunction

  logic [PA_W-1:0] pa_q, addr_q;
  logic [5:0]      s_q;
  logic [4:0]      p_q;

  wire        cfg_bad   = (cfg_pps > 3'd6) || (cfg_pgs == 2'b11) || (cfg_l0sz > 4'd9);
  wire [5:0]  s_in      = {2'b00, cfg_l0sz} + 6'd30;
  wire        out_range = (req_pa >> t_of(cfg_pps)) != '0;
  wire [PA_W-1:0] l0_addr = cfg_l0_base + ((req_pa >> s_in) << 3);

  wire [5:0]      l1_w    = s_q - {1'b0, p_q} - 6'd4;
  wire [PA_W-1:0] l1_idx  = (pa_q >> (p_q + 5'd4)) & ((PA_W'(1) << l1_w) - PA_W'(1));
  wire [PA_W-1:0] l1_base = {mem_rsp_data[PA_W-1:12], 12'b0};
  wire [3:0]      nib     = 4'(pa_q >> p_q);
  wire [3:0]      gran    = 4'(mem_rsp_data >> {nib, 2'b00});

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == L0_REQ) || (st == L1_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (st == RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      pa_q      <= '0;
      addr_q    <= '0;
      s_q       <= '0;
      p_q       <= '0;
      rsp_gpi   <= '0;
      rsp_fault <= 1'b0;
      rsp_kind  <= '0;
      rsp_at_l1 <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          pa_q      <= req_pa;
          s_q       <= s_in;
          p_q       <= p_of(cfg_pgs);
          addr_q    <= l0_addr;
          rsp_gpi   <= '0;
          rsp_fault <= 1'b0;
          rsp_kind  <= '0;
          rsp_at_l1 <= 1'b0;
          if (cfg_bad) begin
            rsp_fault <= 1'b1;
            rsp_kind  <= K_CFG;
            st        <= RESP;
          end else if (out_range) begin
            rsp_fault <= 1'b1;
            rsp_kind  <= K_RANGE;
            st        <= RESP;
          end else begin
            st <= L0_REQ;
          end
        end
        L0_REQ: if (mem_req_ready) st <= L0_WAIT;
        L0_WAIT: if (mem_rsp_valid) begin
          case (mem_rsp_data[3:0])
            4'd1: begin
              rsp_gpi <= mem_rsp_data[7:4];
              st      <= RESP;
            end
            4'd3: begin
              addr_q <= l1_base + (l1_idx << 3);
              st     <= L1_REQ;
            end
            default: begin
              rsp_fault <= 1'b1;
              rsp_kind  <= K_DESC;
              st        <= RESP;
            end
          endcase
        end
        L1_REQ: if (mem_req_ready) st <= L1_WAIT;
        L1_WAIT: if (mem_rsp_valid) begin
          rsp_at_l1 <= 1'b1;
          st        <= RESP;
          if (mem_rsp_data[3:0] == 4'd1) begin
            if (mem_rsp_data[9:8] == 2'd0) begin
              rsp_fault <= 1'b1;
              rsp_kind  <= K_DESC;
            end else begin
              rsp_gpi <= mem_rsp_data[7:4];
            end
          end else begin
            rsp_gpi <= gran;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpt_walker_chk.sv
module gpt_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic [3:0]      rsp_gpi,
  input logic            rsp_fault,
  input logic [1:0]      rsp_kind,
  input logic            rsp_at_l1
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_no_accept_while_reading_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_read_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  assert_memreq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_fault_zero_gpi_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_gpi == 4'd0);

  assert_early_fault_at_l0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault && rsp_kind != 2'd2 |-> !rsp_at_l1);

  assert_kind_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_kind != 2'd3);
endmodule

bind gpt_walker gpt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_gpi(rsp_gpi),
  .rsp_fault(rsp_fault), .rsp_kind(rsp_kind), .rsp_at_l1(rsp_at_l1)
);

// File: tb/tb_gpt_walker.sv
module tb_gpt_walker;
  localparam int PA_W = 52;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [PA_W-1:0] req_pa = '0;
  logic [2:0]      cfg_pps = '0;
  logic [1:0]      cfg_pgs = '0;
  logic [3:0]      cfg_l0sz = '0;
  logic [PA_W-1:0] cfg_l0_base = PA_W'(64'h10000);
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b1;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            rsp_valid;
  logic [3:0]      rsp_gpi;
  logic            rsp_fault;
  logic [1:0]      rsp_kind;
  logic            rsp_at_l1;

  gpt_walker #(.PA_W(PA_W)) dut (.*);

  typedef struct {
    logic [3:0] gpi;
    logic       fault;
    logic [1:0] kind;
    logic       at_l1;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0, n_fail = 0, reads = 0;
  logic [63:0] mem [longint];
  bit          pend = 0;
  longint      paddr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
      pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (rst_n && mem_req_valid) begin
      pend  = 1;
      paddr = longint'(mem_req_addr);
      reads++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R12", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_gpi == e.gpi, e.tag, "gpi", rsp_gpi, e.gpi);
        chk(rsp_fault == e.fault, e.tag, "fault", rsp_fault, e.fault);
        if (e.fault) chk(rsp_kind == e.kind, e.tag, "kind", rsp_kind, e.kind);
        chk(rsp_at_l1 == e.at_l1, e.tag, "at_l1", rsp_at_l1, e.at_l1);
      end
    end
  end

  task automatic walk(input logic [PA_W-1:0] pa, input logic [2:0] pps,
                      input logic [1:0] pgs, input logic [3:0] l0sz,
                      input logic [3:0] gpi, input logic fault, input logic [1:0] kind,
                      input logic at_l1, input int nrd, input string tag);
    exp_t e;
    int   r0;
    e.gpi = gpi; e.fault = fault; e.kind = kind; e.at_l1 = at_l1; e.tag = tag;
    sb.push_back(e);
    r0 = reads;
    @(negedge clk);
    req_pa = pa; cfg_pps = pps; cfg_pgs = pgs; cfg_l0sz = l0sz;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
    while (sb.size() != 0) @(negedge clk);
    chk(reads - r0 == nrd, tag, "memory reads", reads - r0, nrd);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mem[64'h10008]  = 64'h51;
    mem[64'h10010]  = 64'h200003;
    mem[64'h10018]  = 64'h7;
    mem[64'h10000]  = 64'h61;
    mem[64'h10028]  = 64'h71;
    mem[64'h10020]  = 64'hFFF0_0000_0030_0FF3;
    mem[64'h200028] = 64'hC000_0000_A000_0009;
    mem[64'h200030] = 64'h2B1;
    mem[64'h200038] = 64'hB1;
    mem[64'h200008] = 64'hD000;
    mem[64'h200010] = 64'hE_0000;
    mem[64'h300000] = 64'h400;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R1", "reset ready known", req_ready, 1);
    chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R12", "reset mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);

    // R5 block at level 0, index 1 with S=30
    walk(52'h4000_0000, 3'd0, 2'd0, 4'd0, 4'h5, 0, 0, 0, 1, "R5");
    // R8 granule nibbles 7, 0, 15 via table (R7)
    walk(52'h8005_7000, 3'd0, 2'd0, 4'd0, 4'hA, 0, 0, 1, 2, "R8");
    walk(52'h8005_0000, 3'd0, 2'd0, 4'd0, 4'h9, 0, 0, 1, 2, "R8");
    walk(52'h8005_F000, 3'd0, 2'd0, 4'd0, 4'hC, 0, 0, 1, 2, "R8");
    // R9 contiguous run, size code 2
    walk(52'h8006_3000, 3'd0, 2'd0, 4'd0, 4'hB, 0, 0, 1, 2, "R9");
    // R9 contiguous with size code 0
    walk(52'h8007_0000, 3'd0, 2'd0, 4'd0, 4'h0, 1, 2, 1, 2, "R9");
    // R6 bad level-0 type 7
    walk(52'hC000_0000, 3'd0, 2'd0, 4'd0, 4'h0, 1, 2, 0, 1, "R6");
    // R6 unwritten entry (type 0) far out with T=52 (R11)
    walk(52'h8_0000_0000_0000, 3'd6, 2'd0, 4'd0, 4'h0, 1, 2, 0, 1, "R11");
    // R3 range faults
    walk(52'h1_0000_0000, 3'd0, 2'd0, 4'd0, 4'h0, 1, 1, 0, 0, "R3");
    walk(52'h10_0000_0000, 3'd1, 2'd0, 4'd0, 4'h0, 1, 1, 0, 0, "R3");
    // R2 configuration faults
    walk(52'h4000_0000, 3'd7, 2'd0, 4'd0, 4'h0, 1, 0, 0, 0, "R2");
    walk(52'h4000_0000, 3'd0, 2'd3, 4'd0, 4'h0, 1, 0, 0, 0, "R2");
    walk(52'h4000_0000, 3'd0, 2'd0, 4'd10, 4'h0, 1, 0, 0, 0, "R2");
    // R4 S equals T: single entry at base
    walk(52'hC000_0000, 3'd0, 2'd0, 4'd2, 4'h6, 0, 0, 0, 1, "R4");
    // R11 T=36 allows index 5
    walk(52'h1_4000_0000, 3'd1, 2'd0, 4'd0, 4'h7, 0, 0, 0, 1, "R11");
    // R10 granule codes 2 (P=14) and 1 (P=16)
    walk(52'h8004_C000, 3'd0, 2'd2, 4'd0, 4'hD, 0, 0, 1, 2, "R10");
    walk(52'h8024_0000, 3'd0, 2'd1, 4'd0, 4'hE, 0, 0, 1, 2, "R10");
    // R7 table base with junk outside [51:12]
    walk(52'h1_0000_2000, 3'd1, 2'd0, 4'd0, 4'h4, 0, 0, 1, 2, "R7");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule